// File: doc/BRIEF.md
# Write-Channel Burst Target with Ordered Response

This block is the write half of a memory-mapped slave on an AXI4 bus. It takes burst addresses on the address channel and data beats on the data channel, and it writes each beat into a small internal word array. It returns one write response per burst. The address and data channels are fully independent. A master may push a whole burst of data before it presents the address, may present both in the same cycle, or may present the address first.

Every accepted data beat first enters a beat buffer that holds one maximum-length burst. The buffer drains into the array only while a burst address is held. Each drained beat goes to the next word of an incrementing burst. The response becomes valid only after the beat marked last has left the buffer and been written, and only when the burst's address has already been taken. The response is then offered with no regard to the master's ready signal, and it stays on the bus until the master accepts it. Only one burst is in progress at a time. Every burst completes with an OKAY status. A combinational lookup port exposes any word of the array to the neighbouring read logic.

Top module: `wr_burst_target`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), resp_valid is 0, aw_ready is 1, w_ready is 1, and every array word reads 0.
- R2: Once an address is accepted (aw_valid and aw_ready both high at an edge), aw_ready stays 0 until the edge at which resp_valid and resp_ready are both high. Only one burst is outstanding at any time.
- R3: Data beats are accepted whether the address comes before, with, or after them. Up to 16 beats are held while no address is pending. w_ready is 0 while 16 beats are held.
- R4: Beat k of a burst with start byte address A is written to word index ((A >> 2) + k) mod 16. Bit j of w_strb enables byte lane j, meaning bits 8j+7 to 8j. Lanes whose strobe bit is clear keep their old value.
- R5: resp_valid stays 0 until the beat carrying w_last has been accepted and the burst's address has been accepted. No response appears while the beats of a burst are still being sent.
- R6: resp_valid is raised without waiting for resp_ready. Once high, it stays high with a stable resp_code until it is sampled together with resp_ready high. It is 0 on the cycle after that handshake.
- R7: resp_code is always 2'b00 (OKAY) while resp_valid is high.
- R8: rd_word shows, combinationally, the array word selected by rd_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| aw_addr | input | 6 | Byte start address of a burst |
| aw_valid | input | 1 | Burst address offered |
| aw_ready | output | 1 | Burst address can be taken |
| w_data | input | 32 | Write data beat |
| w_strb | input | 4 | Byte lane enables of the beat |
| w_last | input | 1 | Beat is the final one of its burst |
| w_valid | input | 1 | Data beat offered |
| w_ready | output | 1 | Data beat can be taken |
| resp_code | output | 2 | Write response status |
| resp_valid | output | 1 | Write response offered |
| resp_ready | input | 1 | Master takes the response |
| rd_idx | input | 4 | Word index for the lookup port |
| rd_word | output | 32 | Array word at rd_idx |

## Verification
The checker assumes the master sends bursts in order. Each burst has exactly one w_last beat and at most 16 beats, and a burst's beats never run ahead of the buffer space. From these assumptions, the checker's count of accepted last beats and open addresses stays a valid bound on when a response may appear. The stimulus keeps every burst between 1 and 16 beats long and always ends a burst with w_last. It deasserts aw_valid before releasing resp_ready, so the held-address check and the response-hold check both look at well-formed traffic.

// File: rtl/wbs_pkg.sv
// Shared definitions for the write burst target.
// Assumes: full-width beats only, one burst in flight.
package wbs_pkg;

    // Burst sequencer state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a burst address
        ST_FILL = 2'd1,   // draining buffered beats into the array
        ST_RESP = 2'd2    // offering the write response
    } wbs_state_e;

    // Response status: only OKAY is ever returned
    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/wbs_beat_buf.sv
// Beat buffer: a first-in first-out store of {last, strobe, data} beats.
// Assumes: push is only raised when full is low, pop only when empty is low.
module wbs_beat_buf #(
    parameter int WIDTH = 37,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill;

    // Store the incoming beat in the slot at the write pointer
    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and track the occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign full  = (fill == CNT_W'(DEPTH));
    assign empty = (fill == '0);

endmodule

// File: rtl/wbs_regfile.sv
// Word array with per-byte-lane write enables and a combinational read port.
// Assumes: DATA_W is a multiple of 8; all words clear on reset.
module wbs_regfile #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_strb,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DATA_W-1:0]   rd_word
);
    localparam int LANES = DATA_W / 8;
    localparam int WORDS = 1 << IDX_W;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [7:0] lane_mem [WORDS];

        // Clear the lane on reset, else update the addressed byte when enabled
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < WORDS; w++) begin
                    lane_mem[w] <= '0;
                end
            end else if (wr_en && wr_strb[ln]) begin
                lane_mem[wr_idx] <= wr_data[8*ln +: 8];
            end
        end

        assign rd_word[8*ln +: 8] = lane_mem[rd_idx];
    end

endmodule

// File: rtl/wbs_burst_ctrl.sv
// Burst sequencer: holds one burst address, walks it across buffered beats,
// and offers the response once the final beat has been written.
// Assumes: beats arrive in burst order and each burst ends with a last beat.
module wbs_burst_ctrl
    import wbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic              buf_empty,
    input  logic              head_last,
    output logic              buf_pop,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              resp_valid,
    input  logic              resp_ready
);
    localparam int BYTES = DATA_W / 8;

    wbs_state_e        state;
    logic [ADDR_W-1:0] addr_q;

    // Step through idle, fill and response phases; advance the beat address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (aw_valid) begin
                        addr_q <= aw_addr;
                        state  <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (!buf_empty) begin
                        addr_q <= addr_q + ADDR_W'(BYTES);
                        if (head_last) begin
                            state <= ST_RESP;
                        end
                    end
                end
                ST_RESP: begin
                    if (resp_ready) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign aw_ready   = (state == ST_IDLE);
    assign buf_pop    = (state == ST_FILL) && !buf_empty;
    assign beat_addr  = addr_q;
    assign resp_valid = (state == ST_RESP);

endmodule

// File: rtl/wr_burst_target.sv
// Write burst target: AXI4-style write address, data and response channels
// in front of a small word array. Beats are buffered so data may lead the
// address; the response is gated on the last beat being written.
// Assumes: single ID, in-order bursts, full-width beats, incrementing bursts.
module wr_burst_target #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 6,
    parameter int MAX_BEATS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   aw_addr,
    input  logic                aw_valid,
    output logic                aw_ready,
    input  logic [DATA_W-1:0]   w_data,
    input  logic [DATA_W/8-1:0] w_strb,
    input  logic                w_last,
    input  logic                w_valid,
    output logic                w_ready,
    output logic [1:0]          resp_code,
    output logic                resp_valid,
    input  logic                resp_ready,
    input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] rd_idx,
    output logic [DATA_W-1:0]   rd_word
);
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);
    localparam int IDX_W  = ADDR_W - OFF_W;
    localparam int BEAT_W = 1 + LANES + DATA_W;

    logic              buf_full;
    logic              buf_empty;
    logic              buf_pop;
    logic [BEAT_W-1:0] head;
    logic [ADDR_W-1:0] beat_addr;

    // Beat buffer: takes every data beat as long as it has room
    wbs_beat_buf #(
        .WIDTH (BEAT_W),
        .DEPTH (MAX_BEATS)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (w_valid && !buf_full),
        .push_data ({w_last, w_strb, w_data}),
        .pop       (buf_pop),
        .head      (head),
        .full      (buf_full),
        .empty     (buf_empty)
    );

    // Sequencer: address hold, beat walking and response gating
    wbs_burst_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .aw_addr    (aw_addr),
        .aw_valid   (aw_valid),
        .aw_ready   (aw_ready),
        .buf_empty  (buf_empty),
        .head_last  (head[BEAT_W-1]),
        .buf_pop    (buf_pop),
        .beat_addr  (beat_addr),
        .resp_valid (resp_valid),
        .resp_ready (resp_ready)
    );

    // Word array written by the beat leaving the buffer
    wbs_regfile #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_pop),
        .wr_idx  (beat_addr[ADDR_W-1:OFF_W]),
        .wr_data (head[DATA_W-1:0]),
        .wr_strb (head[DATA_W +: LANES]),
        .rd_idx  (rd_idx),
        .rd_word (rd_word)
    );

    assign w_ready   = !buf_full;
    assign resp_code = wbs_pkg::RESP_OKAY;

endmodule

// File: rtl/wbs_checker.sv
// Protocol checker for the write burst target, watching its ports only.
// Assumes: the master ends every burst with one last beat and sends bursts in order.
module wbs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       aw_valid,
    input logic       aw_ready,
    input logic       w_valid,
    input logic       w_ready,
    input logic       w_last,
    input logic [1:0] resp_code,
    input logic       resp_valid,
    input logic       resp_ready
);
    logic       aw_open;
    logic [5:0] lasts_pending;
    logic       aw_hs;
    logic       last_hs;
    logic       b_hs;

    assign aw_hs   = aw_valid && aw_ready;
    assign last_hs = w_valid && w_ready && w_last;
    assign b_hs    = resp_valid && resp_ready;

    // Track an accepted address until its response handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_open <= 1'b0;
        end else if (aw_hs) begin
            aw_open <= 1'b1;
        end else if (b_hs) begin
            aw_open <= 1'b0;
        end
    end

    // Count accepted last beats not yet answered by a response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lasts_pending <= '0;
        end else begin
            case ({last_hs, b_hs})
                2'b10:   lasts_pending <= lasts_pending + 1'b1;
                2'b01:   lasts_pending <= lasts_pending - 1'b1;
                default: lasts_pending <= lasts_pending;
            endcase
        end
    end

    // R2: no second address while one is open
    a_r2_single_burst: assert property (@(posedge clk) disable iff (!rst_n)
        aw_open |-> !aw_ready);

    // R5: response only after the final data beat was accepted
    a_r5_resp_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (lasts_pending != 6'd0));

    // R5: response only after the burst address was accepted
    a_r5_resp_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> aw_open);

    // R6: an unaccepted response stays up with the same status
    a_r6_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_code)));

    // R7: status is always OKAY
    a_r7_okay: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_code == 2'b00));

endmodule

bind wr_burst_target wbs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .aw_valid   (aw_valid),
    .aw_ready   (aw_ready),
    .w_valid    (w_valid),
    .w_ready    (w_ready),
    .w_last     (w_last),
    .resp_code  (resp_code),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready)
);

// File: tb/wr_burst_target_tb.sv
`timescale 1ns/1ps
module wr_burst_target_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  aw_addr = '0;
    logic        aw_valid = 1'b0;
    logic        aw_ready;
    logic [31:0] w_data = '0;
    logic [3:0]  w_strb = '0;
    logic        w_last = 1'b0;
    logic        w_valid = 1'b0;
    logic        w_ready;
    logic [1:0]  resp_code;
    logic        resp_valid;
    logic        resp_ready = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_word;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_mem [16];

    always #2.5 clk = ~clk;

    wr_burst_target u_dut (
        .clk(clk), .rst_n(rst_n),
        .aw_addr(aw_addr), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
        .w_valid(w_valid), .w_ready(w_ready),
        .resp_code(resp_code), .resp_valid(resp_valid), .resp_ready(resp_ready),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] beat_data(input int seed, input int b);
        return 32'(seed) * 32'h01000193 + 32'(b) * 32'h00010203 + 32'h11;
    endfunction

    function automatic logic [3:0] beat_strb(input bit partial, input int b);
        if (!partial) return 4'hF;
        return (b % 2 == 0) ? 4'b0101 : 4'b1010;
    endfunction

    // Reference model: apply one burst to the expected array (R4)
    task automatic model_burst(input logic [5:0] addr, input int n,
                               input int seed, input bit partial);
        for (int b = 0; b < n; b++) begin
            int idx = (int'(addr >> 2) + b) % 16;
            logic [31:0] d = beat_data(seed, b);
            logic [3:0]  s = beat_strb(partial, b);
            for (int ln = 0; ln < 4; ln++) begin
                if (s[ln]) exp_mem[idx][8*ln +: 8] = d[8*ln +: 8];
            end
        end
    endtask

    task automatic send_aw(input logic [5:0] addr);
        int guard = 0;
        @(negedge clk);
        aw_addr  = addr;
        aw_valid = 1'b1;
        while (!aw_ready && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 1000, "R2", "address accepted", 32'(guard), 0);
        @(posedge clk);
        @(negedge clk);
        aw_valid = 1'b0;
    endtask

    // Send a burst; before each beat, no response may be showing (R5)
    task automatic send_w(input int n, input int seed, input bit partial);
        for (int b = 0; b < n; b++) begin
            int guard = 0;
            @(negedge clk);
            w_data  = beat_data(seed, b);
            w_strb  = beat_strb(partial, b);
            w_last  = (b == n - 1);
            w_valid = 1'b1;
            while (!w_ready && guard < 1000) begin
                @(negedge clk);
                guard++;
            end
            chk(!resp_valid, "R5", "no response before last beat", 32'(resp_valid), 0);
            chk(guard < 1000, "R3", "beat accepted", 32'(guard), 0);
            @(posedge clk);
        end
        @(negedge clk);
        w_valid = 1'b0;
        w_last  = 1'b0;
    endtask

    // Await the response, hold ready low for some cycles, then take it (R6, R7)
    task automatic take_b(input int hold, input bit probe_aw);
        int guard = 0;
        @(negedge clk);
        while (!resp_valid && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        chk(resp_valid, "R6", "response raised with ready low", 32'(resp_valid), 1);
        chk(resp_code == 2'b00, "R7", "status OKAY", 32'(resp_code), 0);
        if (probe_aw) aw_valid = 1'b1;
        for (int c = 0; c < hold; c++) begin
            @(negedge clk);
            chk(resp_valid, "R6", "response held", 32'(resp_valid), 1);
            chk(resp_code == 2'b00, "R7", "status stays OKAY", 32'(resp_code), 0);
            if (probe_aw) chk(!aw_ready, "R2", "address blocked while open", 32'(aw_ready), 0);
        end
        aw_valid   = 1'b0;
        resp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        resp_ready = 1'b0;
        chk(!resp_valid, "R6", "response dropped after handshake", 32'(resp_valid), 0);
        chk(aw_ready, "R2", "address reopened after response", 32'(aw_ready), 1);
    endtask

    task automatic check_array(input string tag);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd_idx = 4'(i);
            #1;
            chk(rd_word == exp_mem[i], "R4", {tag, " word (R8 lookup)"}, rd_word, exp_mem[i]);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary
    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(!resp_valid, "R1", "resp_valid after reset", 32'(resp_valid), 0);
        chk(aw_ready, "R1", "aw_ready after reset", 32'(aw_ready), 1);
        chk(w_ready, "R1", "w_ready after reset", 32'(w_ready), 1);
        check_array("R1 reset");

        // Address first, then data
        send_aw(6'h08);
        send_w(4, 1, 1'b0);
        model_burst(6'h08, 4, 1, 1'b0);
        take_b(0, 1'b0);
        check_array("addr-first");

        // R3: data first, whole burst accepted with no address yet
        send_w(8, 2, 1'b0);
        chk(!resp_valid, "R5", "no response without address", 32'(resp_valid), 0);
        send_aw(6'h10);
        model_burst(6'h10, 8, 2, 1'b0);
        take_b(2, 1'b0);
        check_array("data-first");

        // Address and data together
        fork
            send_aw(6'h00);
            send_w(5, 3, 1'b0);
        join
        model_burst(6'h00, 5, 3, 1'b0);
        take_b(1, 1'b0);
        check_array("together");

        // R3: sixteen beats fill the buffer, w_ready drops
        send_w(16, 4, 1'b0);
        chk(!w_ready, "R3", "w_ready low with 16 buffered", 32'(w_ready), 0);
        repeat (3) begin
            @(negedge clk);
            chk(!resp_valid, "R5", "no response while address missing", 32'(resp_valid), 0);
        end
        send_aw(6'h04);
        model_burst(6'h04, 16, 4, 1'b0);
        take_b(0, 1'b0);
        chk(w_ready, "R3", "w_ready back after drain", 32'(w_ready), 1);
        check_array("full-buffer");

        // R4: partial strobes and wrap past the top word; R2 probe during hold
        send_aw(6'h38);
        send_w(4, 5, 1'b1);
        model_burst(6'h38, 4, 5, 1'b1);
        take_b(5, 1'b1);
        check_array("wrap-strobe");

        // Single-beat burst with alternating strobe pattern
        fork
            send_w(1, 6, 1'b1);
            begin
                repeat (2) @(negedge clk);
                send_aw(6'h2C);
            end
        join
        model_burst(6'h2C, 1, 6, 1'b1);
        take_b(3, 1'b0);
        check_array("single-beat");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule